// File: doc/BRIEF.md
# Prioritized Nested Interrupt Controller

This block collects a set of level-sensitive interrupt request lines and decides which of them, if any, may interrupt the core. Each source has a priority level that software writes through a small configuration port, normally once after reset. The block also holds the level of the code now running on the core. It raises a request only when a latched source has a level strictly above that running level. Level 0 is the application level, and a source left at level 0 never interrupts.

When the core accepts the request, the block saves the running level on an internal stack and adopts the winner's level. It also clears the winner's latched request. An end-of-interrupt pulse restores the saved level. A handler can therefore be preempted by any strictly more urgent source while the global enable stays on. Sources that share the winning level are served in rotation: after a grant, the next choice at that level starts from the source just past the one last granted.

A stack overflow on accept, or an end-of-interrupt with nothing saved, sets a sticky error flag. In either case all other state is left unchanged.

Top module: `prio_irq_ctrl`

## Requirements
- R1: Writing `cfg_we` stores `cfg_lvl` as the level of source `cfg_idx`, and the new level applies to a source that is already latched. All levels reset to 0, and a source at level 0 never produces a request.
- R2: A request line high at a rising clock edge latches that source. The latch stays set until the source is granted, even if the line falls or the global enable is low, and it shows on the outputs after that edge.
- R3: `irq_req_o` is high exactly when `gie_i` is high and the winning level is above `cur_lvl_o`.
- R4: `win_lvl_o` is the highest level among latched sources whose level is nonzero, and `win_id_o` is one such source. When no latched source qualifies, both outputs read 0.
- R5: Among latched sources at the winning level, the block picks the first one in ascending index order, wrapping from NSRC-1 to 0, that follows the source last granted at that level. After reset that last-granted source is taken as NSRC-1.
- R6: When `ack_i` is high at an edge where `irq_req_o` is high, the block saves `cur_lvl_o`, sets `cur_lvl_o` to the winning level and clears the winner's latch. When `ack_i` is high while `irq_req_o` is low, nothing changes.
- R7: `eoi_i` restores `cur_lvl_o` to the most recently saved level. If an accepted acknowledge falls on the same edge, the end-of-interrupt is ignored.
- R8: An accepted acknowledge when DEPTH levels are already saved sets `err_o`. The running level, the stack and the latches all stay as they were.
- R9: An end-of-interrupt with no saved level sets `err_o` and leaves `cur_lvl_o` unchanged. `err_o` stays set until reset.
- R10: After reset `irq_req_o`, `win_id_o`, `win_lvl_o`, `cur_lvl_o` and `err_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_i | input | NSRC | Level-sensitive request lines |
| gie_i | input | 1 | Global interrupt enable |
| cfg_we | input | 1 | Write strobe for a source level |
| cfg_idx | input | $clog2(NSRC) | Source to configure |
| cfg_lvl | input | LVLW | Level to store |
| ack_i | input | 1 | Core accepts the current request |
| eoi_i | input | 1 | Handler finished; restore saved level |
| irq_req_o | output | 1 | Request to the core |
| win_id_o | output | $clog2(NSRC) | Winning source |
| win_lvl_o | output | LVLW | Winning level |
| cur_lvl_o | output | LVLW | Level of the running code |
| err_o | output | 1 | Sticky stack overflow/underflow flag |

## Verification
A request line, an acknowledge, an end-of-interrupt or a level write takes effect at the next rising edge. The outputs are combinational from the registered state and `gie_i`, so each result is due one edge after its stimulus. The bench applies every stimulus on a falling edge and compares all five outputs on the following falling edge, after exactly one rising edge. A change of `gie_i` alone acts with no edge, and the same sampling point covers it.

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int NSRC  = 8,
  parameter int LVLW  = 3,
  parameter int DEPTH = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NSRC-1:0]         irq_i,
  input  logic                    gie_i,
  input  logic                    cfg_we,
  input  logic [$clog2(NSRC)-1:0] cfg_idx,
  input  logic [LVLW-1:0]         cfg_lvl,
  input  logic                    ack_i,
  input  logic                    eoi_i,
  output logic                    irq_req_o,
  output logic [$clog2(NSRC)-1:0] win_id_o,
  output logic [LVLW-1:0]         win_lvl_o,
  output logic [LVLW-1:0]         cur_lvl_o,
  output logic                    err_o
);
  localparam int IDW  = $clog2(NSRC);
  localparam int NLVL = 1 << LVLW;
  localparam int SPW  = $clog2(DEPTH + 1);
  localparam int SIW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [LVLW-1:0] lvl_q [NSRC];
  logic [IDW-1:0]  last_q [NLVL];
  logic [LVLW-1:0] stk_q [DEPTH];
  logic [NSRC-1:0] pend_q;
  logic [SPW-1:0]  sp_q;
  logic [LVLW-1:0] cur_q;
  logic            err_q;

  logic [LVLW-1:0] best;
  logic [IDW-1:0]  pick;
  logic            found;

  always_comb begin
    best = '0;
    for (int i = 0; i < NSRC; i++)
      if (pend_q[i] && lvl_q[i] > best) best = lvl_q[i];
    pick  = '0;
    found = 1'b0;
    for (int k = 1; k <= NSRC; k++) begin
      int j;
      j = (int'(last_q[best]) + k) % NSRC;
      if (!found && best != '0 && pend_q[j] && lvl_q[j] == best) begin
        pick  = IDW'(j);
        found = 1'b1;
      end
    end
  end

  wire             full     = (sp_q == SPW'(DEPTH));
  wire             empty    = (sp_q == '0);
  wire             req      = gie_i && (best > cur_q);
  wire             take_ack = ack_i && req;
  wire             push_ok  = take_ack && !full;
  wire             take_eoi = eoi_i && !take_ack;
  wire             pop_ok   = take_eoi && !empty;
  wire [SPW-1:0]   sp_dn    = sp_q - 1'b1;
  wire [NSRC-1:0]  clr      = push_ok ? (NSRC'(1) << pick) : '0;

  assign irq_req_o = req;
  assign win_id_o  = pick;
  assign win_lvl_o = best;
  assign cur_lvl_o = cur_q;
  assign err_o     = err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NSRC; i++) lvl_q[i] <= '0;
      for (int l = 0; l < NLVL; l++) last_q[l] <= IDW'(NSRC - 1);
      pend_q <= '0;
      sp_q   <= '0;
      cur_q  <= '0;
      err_q  <= 1'b0;
    end else begin
      if (cfg_we) lvl_q[cfg_idx] <= cfg_lvl;
      pend_q <= (pend_q | irq_i) & ~clr;
      if (push_ok) begin
        sp_q         <= sp_q + 1'b1;
        cur_q        <= best;
        last_q[best] <= pick;
      end else if (pop_ok) begin
        sp_q  <= sp_dn;
        cur_q <= stk_q[sp_dn[SIW-1:0]];
      end
      if ((take_ack && full) || (take_eoi && empty)) err_q <= 1'b1;
    end
  end

  always_ff @(posedge clk)
    if (push_ok) stk_q[sp_q[SIW-1:0]] <= cur_q;

  assert_ack_adopts_R6: assert property (@(posedge clk) disable iff (!rst_n)
    push_ok |=> (cur_lvl_o == $past(win_lvl_o)) && (sp_q == $past(sp_q) + 1'b1));

  assert_granted_cleared_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (push_ok && !irq_i[pick]) |=> !pend_q[$past(pick)]);

  assert_win_latched_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (win_lvl_o != '0) |-> (pend_q[win_id_o] && lvl_q[win_id_o] == win_lvl_o));

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (take_ack && full) |=> err_o && $stable(cur_lvl_o) && $stable(sp_q));

  assert_underflow_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (take_eoi && empty) |=> err_o && $stable(cur_lvl_o));

  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> err_o);

  assert_sp_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sp_q <= SPW'(DEPTH));

  assert_req_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req_o |-> (win_lvl_o > cur_lvl_o) && gie_i);
endmodule

// File: tb/tb_prio_irq_ctrl.sv
module tb_prio_irq_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] irq = '0;
  logic       gie = 1'b0, cfg_we = 1'b0, ack = 1'b0, eoi = 1'b0;
  logic [2:0] cfg_idx = '0, cfg_lvl = '0;
  logic       req, err;
  logic [2:0] wid, wlvl, cur;

  logic [7:0] b_irq = '0;
  logic       b_cfg_we = 1'b0, b_ack = 1'b0, b_eoi = 1'b0;
  logic [2:0] b_cfg_idx = '0, b_cfg_lvl = '0;
  logic       b_req, b_err;
  logic [2:0] b_wid, b_wlvl, b_cur;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  prio_irq_ctrl dut (.clk(clk), .rst_n(rst_n), .irq_i(irq), .gie_i(gie),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_lvl(cfg_lvl), .ack_i(ack), .eoi_i(eoi),
    .irq_req_o(req), .win_id_o(wid), .win_lvl_o(wlvl), .cur_lvl_o(cur), .err_o(err));

  prio_irq_ctrl #(.NSRC(8), .LVLW(3), .DEPTH(2)) dut2 (.clk(clk), .rst_n(rst_n),
    .irq_i(b_irq), .gie_i(1'b1), .cfg_we(b_cfg_we), .cfg_idx(b_cfg_idx),
    .cfg_lvl(b_cfg_lvl), .ack_i(b_ack), .eoi_i(b_eoi), .irq_req_o(b_req),
    .win_id_o(b_wid), .win_lvl_o(b_wlvl), .cur_lvl_o(b_cur), .err_o(b_err));

  // {irq[8], gie, ack, eoi, req, id[3], lvl[3], cur[3], err}
  // levels: s0,s1=2  s2,s3=5  s4=7  s5=0  s6,s7=3
  localparam logic [21:0] VEC [26] = '{
    {8'h20, 3'b100, 1'b0, 3'd0, 3'd0, 3'd0, 1'b0},  // R1 level-0 source silent
    {8'h03, 3'b100, 1'b1, 3'd0, 3'd2, 3'd0, 1'b0},  // R2 R3 R5
    {8'h00, 3'b110, 1'b0, 3'd1, 3'd2, 3'd2, 1'b0},  // R6
    {8'h04, 3'b100, 1'b1, 3'd2, 3'd5, 3'd2, 1'b0},  // R3 preempt
    {8'h08, 3'b110, 1'b0, 3'd3, 3'd5, 3'd5, 1'b0},  // R6 nested
    {8'h00, 3'b101, 1'b1, 3'd3, 3'd5, 3'd2, 1'b0},  // R7
    {8'h00, 3'b110, 1'b0, 3'd1, 3'd2, 3'd5, 1'b0},
    {8'h00, 3'b101, 1'b0, 3'd1, 3'd2, 3'd2, 1'b0},  // R3 equal not above
    {8'h00, 3'b101, 1'b1, 3'd1, 3'd2, 3'd0, 1'b0},
    {8'h00, 3'b110, 1'b0, 3'd0, 3'd0, 3'd2, 1'b0},  // R4 none
    {8'h00, 3'b101, 1'b0, 3'd0, 3'd0, 3'd0, 1'b0},
    {8'h03, 3'b100, 1'b1, 3'd0, 3'd2, 3'd0, 1'b0},  // R5 wrap to 0
    {8'h00, 3'b110, 1'b0, 3'd1, 3'd2, 3'd2, 1'b0},
    {8'h01, 3'b101, 1'b1, 3'd1, 3'd2, 3'd0, 1'b0},  // R5 1 before 0
    {8'h00, 3'b110, 1'b0, 3'd0, 3'd2, 3'd2, 1'b0},
    {8'h00, 3'b101, 1'b1, 3'd0, 3'd2, 3'd0, 1'b0},
    {8'h02, 3'b110, 1'b0, 3'd1, 3'd2, 3'd2, 1'b0},
    {8'h00, 3'b101, 1'b1, 3'd1, 3'd2, 3'd0, 1'b0},
    {8'h10, 3'b000, 1'b0, 3'd4, 3'd7, 3'd0, 1'b0},  // R3 gie low
    {8'h00, 3'b010, 1'b0, 3'd4, 3'd7, 3'd0, 1'b0},  // R6 ack ignored
    {8'h00, 3'b100, 1'b1, 3'd4, 3'd7, 3'd0, 1'b0},  // R2 kept while masked
    {8'h00, 3'b110, 1'b0, 3'd1, 3'd2, 3'd7, 1'b0},
    {8'h00, 3'b101, 1'b1, 3'd1, 3'd2, 3'd0, 1'b0},
    {8'h00, 3'b110, 1'b0, 3'd0, 3'd0, 3'd2, 1'b0},
    {8'h00, 3'b101, 1'b0, 3'd0, 3'd0, 3'd0, 1'b0},
    {8'h00, 3'b101, 1'b0, 3'd0, 3'd0, 3'd0, 1'b1}   // R9 underflow
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cfg(input int idx, input int lvl);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 3'(idx); cfg_lvl = 3'(lvl);
    b_cfg_we = 1'b1; b_cfg_idx = 3'(idx); b_cfg_lvl = 3'(lvl);
    @(negedge clk);
    cfg_we = 1'b0; b_cfg_we = 1'b0;
  endtask

  task automatic b_step(input logic [7:0] ir, input logic a, input logic e);
    b_irq = ir; b_ack = a; b_eoi = e;
    @(negedge clk);
    b_irq = '0; b_ack = 1'b0; b_eoi = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10 req", req, 0); chk("R10 id", wid, 0); chk("R10 lvl", wlvl, 0);
    chk("R10 cur", cur, 0); chk("R10 err", err, 0);

    cfg(0, 2); cfg(1, 2); cfg(2, 5); cfg(3, 5);
    cfg(4, 7); cfg(5, 0); cfg(6, 3); cfg(7, 3);

    for (int v = 0; v < 26; v++) begin
      irq = VEC[v][21:14];
      {gie, ack, eoi} = VEC[v][13:11];
      @(negedge clk);
      chk("R3 req", req, int'(VEC[v][10]));
      chk("R5 id", wid, int'(VEC[v][9:7]));
      chk("R4 lvl", wlvl, int'(VEC[v][6:4]));
      chk("R6 cur", cur, int'(VEC[v][3:1]));
      chk("R9 err", err, int'(VEC[v][0]));
      irq = '0; ack = 1'b0; eoi = 1'b0;
    end

    // R1: raising a latched level-0 source's level makes it eligible
    cfg(5, 4);
    chk("R1 req", req, 1); chk("R1 id", wid, 5); chk("R1 lvl", wlvl, 4);

    // R8 on a two-deep stack; levels s0=2 s1=2 s2=5 from cfg above
    b_step(8'h01, 1'b0, 1'b0);
    b_step(8'h00, 1'b1, 1'b0);
    chk("R6 cur", b_cur, 2);
    b_step(8'h04, 1'b0, 1'b0);
    b_step(8'h00, 1'b1, 1'b0);
    chk("R6 cur", b_cur, 5);
    @(negedge clk);
    cfg(4, 7);
    b_step(8'h10, 1'b0, 1'b0);
    chk("R3 req", b_req, 1); chk("R4 id", b_wid, 4);
    b_step(8'h00, 1'b1, 1'b0);
    chk("R8 err", b_err, 1); chk("R8 cur", b_cur, 5);
    chk("R8 req", b_req, 1); chk("R8 id", b_wid, 4);
    b_step(8'h00, 1'b0, 1'b1);
    chk("R7 cur", b_cur, 2);
    // R7: accepted ack wins over a simultaneous eoi
    b_step(8'h00, 1'b1, 1'b1);
    chk("R7 cur", b_cur, 7);
    b_step(8'h00, 1'b0, 1'b1);
    chk("R7 cur", b_cur, 2);

    // R10: reset clears the sticky error
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 err", err, 0); chk("R10 cur", cur, 0); chk("R10 req", req, 0);
    chk("R10 err2", b_err, 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule